// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block sorts a 32-bit virtual address into one of a fixed set of address segments. It then decides whether the access goes to the translation lookaside buffer, maps straight into the 29-bit physical space, passes through unchanged, or raises a fault. Each request carries the privilege mode, an instruction-fetch flag, the global translation-enable bit and a flag that suppresses exceptions. The block does not hold TLB contents and does not check page permissions. It only chooses the route.

A decision is registered, so it appears on the outputs one clock after the request is presented with `req_valid` high. The rules are checked in a fixed priority order, and the first rule that applies wins. The route is reported one-hot, and a separate fault flag is given for convenience. When an access is refused but exceptions are suppressed, the block reports a direct mapping to physical address zero instead of a fault.

Top module: `va_region_decoder`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is 0, `rsp_route` is 4'b0000, `rsp_fault` is 0 and `rsp_paddr` is 0.
- R2: The `rsp_route` encoding is one-hot. Bit 0 is TLB, bit 1 is direct, bit 2 is pass-through and bit 3 is fault. While `rsp_valid` is 1, exactly one bit is set. `rsp_fault` equals bit 3. A request accepted with `req_valid`=1 produces `rsp_valid`=1 exactly one clock later.
- R3: An address is translatable if bit 31 is 0, or if it lies in 0xC000_0000..0xDFFF_FFFF. A translatable address with `xlate_en`=1 is routed to the TLB with `rsp_paddr`=0. This applies in every mode and for every access kind.
- R4: A translatable address with `xlate_en`=0 is routed direct, with `rsp_paddr` = address AND 0x1FFF_FFFF.
- R5: An address in 0xE000_0000..0xE3FF_FFFF is routed pass-through with `rsp_paddr` equal to the address. This holds in both modes and for every access kind.
- R6: In user mode (`priv`=0), any other address is routed to fault. When `no_exc`=1 it is instead routed direct with `rsp_paddr`=0.
- R7: In privileged mode, 0x8000_0000..0xBFFF_FFFF is routed direct with `rsp_paddr` = address AND 0x1FFF_FFFF. This applies to fetches as well.
- R8: In privileged mode, an instruction fetch (`ifetch`=1) to 0xE400_0000..0xFFFF_FFFF is routed to fault, even when `no_exc`=1.
- R9: In privileged mode, a data access whose top four address bits are 4'hF is routed pass-through with `rsp_paddr` equal to the address.
- R10: In privileged mode, a data access to 0xE400_0000..0xEFFF_FFFF is routed to fault. When `no_exc`=1 it is instead routed direct with `rsp_paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| vaddr | input | 32 | Virtual address |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| xlate_en | input | 1 | Global address translation enable |
| no_exc | input | 1 | Suppress faults (report zero mapping) |
| rsp_valid | output | 1 | Decision valid |
| rsp_route | output | 4 | One-hot route: bit0 TLB, bit1 direct, bit2 pass, bit3 fault |
| rsp_paddr | output | 32 | Physical address for direct or pass routes, else 0 |
| rsp_fault | output | 1 | Fault decision |

## Verification
Addresses are taken at the edges of every segment: the first and last word of each range, and one interior point. Each is run under all sixteen combinations of mode, fetch, translation enable and suppression. The segment-edge addresses separate neighbouring windows; for example 0xDFFF_FFFF against 0xE000_0000, and 0xE3FF_FFFF against 0xE400_0000. The flag sweep separates the priority levels. It shows that translation enable matters only for translatable segments, and that privilege matters only outside them and the store-queue window. It also shows that suppression rescues every fault except a privileged fetch. Back-to-back requests followed by idle gaps confirm the one-cycle latency and the valid framing.

// File: rtl/va_region_pkg.sv
package va_region_pkg;
  localparam int unsigned ROUTE_W = 4;
  localparam int unsigned RT_TLB  = 0;
  localparam int unsigned RT_DIR  = 1;
  localparam int unsigned RT_PASS = 2;
  localparam int unsigned RT_FLT  = 3;

  typedef struct packed {
    logic xlatable;  // user-low half or kernel virtual segment
    logic sq_win;    // store-queue window
    logic dmap_win;  // privileged direct-mapped window
    logic ctrl_win;  // control-register window (top nibble all ones)
  } seg_flags_t;
endpackage

// File: rtl/va_seg_classify.sv
module va_seg_classify
  import va_region_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output seg_flags_t        seg
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic [2:0] top3;
  logic [5:0] top6;
  logic [3:0] top4;

  always_comb begin
    top3 = addr[TOP -: 3];
    top4 = addr[TOP -: 4];
    top6 = addr[TOP -: 6];
    seg.xlatable = (addr[TOP] == 1'b0) || (top3 == 3'b110);
    seg.sq_win   = (top6 == 6'b111000);
    seg.dmap_win = (addr[TOP -: 2] == 2'b10);
    seg.ctrl_win = (top4 == 4'hF);
  end
endmodule

// File: rtl/va_route_select.sv
module va_route_select
  import va_region_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PHYS_W = 29
) (
  input  logic [ADDR_W-1:0]  addr,
  input  seg_flags_t         seg,
  input  logic               priv,
  input  logic               ifetch,
  input  logic               xlate_en,
  input  logic               no_exc,
  output logic [ROUTE_W-1:0] route,
  output logic [ADDR_W-1:0]  paddr
);
  localparam logic [ADDR_W-1:0] PHYS_MASK = ADDR_W'((64'd1 << PHYS_W) - 64'd1);

  logic [ROUTE_W-1:0] rt_tlb, rt_dir, rt_pass, rt_flt;

  always_comb begin
    rt_tlb  = '0; rt_tlb[RT_TLB]   = 1'b1;
    rt_dir  = '0; rt_dir[RT_DIR]   = 1'b1;
    rt_pass = '0; rt_pass[RT_PASS] = 1'b1;
    rt_flt  = '0; rt_flt[RT_FLT]   = 1'b1;
  end

  // Priority chain: the first rule that applies wins.
  always_comb begin
    route = rt_flt;
    paddr = '0;
    if (seg.xlatable) begin
      if (xlate_en) begin
        route = rt_tlb;
      end else begin
        route = rt_dir;
        paddr = addr & PHYS_MASK;
      end
    end else if (seg.sq_win) begin
      route = rt_pass;
      paddr = addr;
    end else if (!priv) begin
      route = no_exc ? rt_dir : rt_flt;
    end else if (seg.dmap_win) begin
      route = rt_dir;
      paddr = addr & PHYS_MASK;
    end else if (ifetch) begin
      route = rt_flt;
    end else if (seg.ctrl_win) begin
      route = rt_pass;
      paddr = addr;
    end else begin
      route = no_exc ? rt_dir : rt_flt;
    end
  end
endmodule

// File: rtl/va_region_decoder.sv
module va_region_decoder
  import va_region_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PHYS_W = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic               priv,
  input  logic               ifetch,
  input  logic               xlate_en,
  input  logic               no_exc,
  output logic               rsp_valid,
  output logic [ROUTE_W-1:0] rsp_route,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic               rsp_fault
);
  localparam int unsigned TOP = ADDR_W - 1;

  seg_flags_t         seg;
  logic [ROUTE_W-1:0] nxt_route;
  logic [ADDR_W-1:0]  nxt_paddr;

  va_seg_classify #(.ADDR_W(ADDR_W)) u_classify (
    .addr (vaddr),
    .seg  (seg)
  );

  va_route_select #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_select (
    .addr     (vaddr),
    .seg      (seg),
    .priv     (priv),
    .ifetch   (ifetch),
    .xlate_en (xlate_en),
    .no_exc   (no_exc),
    .route    (nxt_route),
    .paddr    (nxt_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_route <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_route <= req_valid ? nxt_route : '0;
      rsp_paddr <= req_valid ? nxt_paddr : '0;
      rsp_fault <= req_valid & nxt_route[RT_FLT];
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot(rsp_route));
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_fault_bit_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_fault == rsp_route[RT_FLT]);
  p_tlb_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !vaddr[TOP] && xlate_en) |=> (rsp_route[RT_TLB] && rsp_paddr == '0));
  p_sq_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vaddr[TOP -: 6] == 6'b111000) |=>
      (rsp_route[RT_PASS] && rsp_paddr == $past(vaddr)));
  p_fetch_fault_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv && ifetch && vaddr[TOP -: 3] == 3'b111 &&
     vaddr[TOP -: 6] != 6'b111000) |=> rsp_fault);
endmodule

// File: tb/test_va_region_decoder.sv
module test_va_region_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        priv = 1'b0, ifetch = 1'b0, xlate_en = 1'b0, no_exc = 1'b0;
  logic        rsp_valid;
  logic [3:0]  rsp_route;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]  route;
    logic [31:0] paddr;
    string       req;
    logic [31:0] va;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  va_region_decoder i_va_region_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .priv(priv), .ifetch(ifetch), .xlate_en(xlate_en), .no_exc(no_exc),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic exp_t model(logic [31:0] a, logic p, logic f, logic x, logic s);
    exp_t e;
    e.va = a;
    e.paddr = 32'h0;
    if (a < 32'h8000_0000 || (a >= 32'hC000_0000 && a <= 32'hDFFF_FFFF)) begin
      if (x) begin e.route = 4'b0001; e.req = "R3"; end
      else begin e.route = 4'b0010; e.paddr = {3'b000, a[28:0]}; e.req = "R4"; end
    end else if (a >= 32'hE000_0000 && a <= 32'hE3FF_FFFF) begin
      e.route = 4'b0100; e.paddr = a; e.req = "R5";
    end else if (!p) begin
      e.route = s ? 4'b0010 : 4'b1000; e.req = "R6";
    end else if (a <= 32'hBFFF_FFFF) begin
      e.route = 4'b0010; e.paddr = {3'b000, a[28:0]}; e.req = "R7";
    end else if (f) begin
      e.route = 4'b1000; e.req = "R8";
    end else if (a >= 32'hF000_0000) begin
      e.route = 4'b0100; e.paddr = a; e.req = "R9";
    end else begin
      e.route = s ? 4'b0010 : 4'b1000; e.req = "R10";
    end
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic p, logic f, logic x, logic s);
    @(negedge clk);
    req_valid = 1'b1; vaddr = a; priv = p; ifetch = f; xlate_en = x; no_exc = s;
    sb.push_back(model(a, p, f, x, s));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      vaddr = 32'hFFFF_FFFF;
    end
  endtask

  // Monitor: compares every valid response against the scoreboard head.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R2 unexpected response route=%b expected none", rsp_route);
        end else begin
          e = sb.pop_front();
          if (rsp_route !== e.route || rsp_paddr !== e.paddr ||
              rsp_fault !== e.route[3]) begin
            failures++;
            $display("FAIL %s va=%h route=%b paddr=%h fault=%b expected route=%b paddr=%h",
                     e.req, e.va, rsp_route, rsp_paddr, rsp_fault, e.route, e.paddr);
          end
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pts[20];
    pts = '{32'h0000_0000, 32'h1234_5678, 32'h7FFF_FFFF, 32'h8000_0000,
            32'h9ABC_DEF0, 32'hBFFF_FFFF, 32'hC000_0000, 32'hCDEF_0123,
            32'hDFFF_FFFF, 32'hE000_0000, 32'hE1234_567 >> 4, 32'hE3FF_FFFF,
            32'hE400_0000, 32'hEABC_0000, 32'hEFFF_FFFF, 32'hF000_0000,
            32'hF8765_432 >> 4, 32'hFFFF_FFFF, 32'hA000_1000, 32'hE3FF_FFFC};
    pts[10] = 32'hE123_4567;
    pts[16] = 32'hF876_5432;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_route !== 4'b0000 || rsp_paddr !== 32'h0 || rsp_fault !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset v=%b route=%b paddr=%h fault=%b expected 0", rsp_valid,
               rsp_route, rsp_paddr, rsp_fault);
    end
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      for (int fl = 0; fl < 16; fl++) begin
        drive(pts[i], fl[0], fl[1], fl[2], fl[3]);
      end
      if (i % 4 == 3) idle(2);
    end
    idle(3);
    // R2: no response without a request, and every item consumed
    checks++;
    if (rsp_valid !== 1'b0 || rsp_route !== 4'b0000 || sb.size() != 0) begin
      failures++;
      $display("FAIL R2 idle v=%b route=%b pending=%0d expected 0 0 0", rsp_valid,
               rsp_route, sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule